// File: doc/BRIEF.md
# Reference Voltage Slew Ramp

This block turns voltage-identifier (VID) commands into the digital code that sets a regulator's reference DAC. The code moves toward each new target at a controlled rate, and each code step stands for 5 mV.

When `enable` rises, the code climbs from zero to the boot code at the soft-start rate of 2.5 mV/µs. It then holds there until the first command arrives. Each later command carries a target VID, a signed offset in VID steps and a slew type. The fast rate is a register value in mV/µs. The slow rate is that value divided by 16, 8, 4 or 2. A decay command moving downward is not paced at all: the code jumps straight to the target.

Pacing uses a fractional accumulator. On every microsecond tick it gains the rate, in quarter-mV units. It gives up 20 quarter-mV (one 5 mV step) for each code step taken, at no more than one step per clock. The `ramping` flag and the one-clock `at_target` strobe tell the sequencer and the alert logic when a paced move has finished.

Top module: `vid_ramp`

## Requirements
- R1: While `enable` is low, `dac_code` is 00h, `ramping` is 0 and `at_target` is 0 from the next clock onward.
- R2: On the rise of `enable`, the code starts at 00h and climbs toward `boot_code` at 2.5 mV/µs, which is one code per two ticks. Reaching N codes takes exactly 2N ticks.
- R3: With `enable` high, no command and `ramping` low, `dac_code` does not change, however many ticks arrive. In particular it holds at the boot code until the first command.
- R4: Slew type 01b (fast) paces at `fast_rate` mV/µs. A move of N codes ends on tick ceil(20N / (4·fast_rate)) after the command.
- R5: Slew type 10b (slow) paces at 4·`fast_rate` >> (4 − `slow_div`) quarter-mV per tick. Here `slow_div` values 0,1,2,3 divide the fast rate by 16, 8, 4 and 2.
- R6: Slew type 11b (decay) with a target below the present code sets `dac_code` to the target on the clock after the command. It raises no `at_target` strobe and leaves `ramping` low.
- R7: A decay command whose target is above the present code is paced at the fast rate.
- R8: The target is `cmd_vid` plus `vid_offset`, read as a two's-complement count of VID steps. The sum is clamped to 00h..FFh and latched when the command is accepted.
- R9: A `cmd_vid` of 00h drives `dac_code` to 00h on the next clock, whatever the offset or slew type. No strobe follows.
- R10: A command during a ramp retargets from the present code. The direction is recomputed and the pacing accumulator is cleared. The abandoned target produces no strobe.
- R11: `at_target` is high for exactly one clock, when a paced move lands on its target, and `ramping` is low in that clock. `ramping` is high from the clock after a command until the code lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-clock pulse per microsecond |
| enable | input | 1 | Regulator enable; low forces the code to zero |
| cmd_load | input | 1 | One-clock pulse accepting a new command |
| cmd_vid | input | CODE_W | Commanded VID code |
| cmd_slew | input | 2 | Slew type: 00 soft, 01 fast, 10 slow, 11 decay |
| vid_offset | input | CODE_W | Signed offset in VID steps |
| boot_code | input | CODE_W | Code reached by the soft-start ramp |
| fast_rate | input | RATE_W | Fast rate in mV/µs |
| slow_div | input | DIV_W | Slow divisor select (/16, /8, /4, /2) |
| dac_code | output | CODE_W | Reference DAC code |
| ramping | output | 1 | A paced move is in progress |
| at_target | output | 1 | One-clock strobe when a paced move lands |

## Verification
Every paced move is checked by the tick on which its strobe appears, not just by the final code. A pacer with the wrong rounding, an accumulator that is not cleared, or the wrong slow-divisor shift would land one or more ticks early or late. The bench goes after the offset clamps at both ends, a downward decay that must jump without a strobe, and an upward decay that must still be paced. It also retargets mid-ramp in the opposite direction; a design that kept the old direction or leftover credit would strobe at the wrong code or tick. Shutdown through VID 00h and an enable drop in mid-ramp must both zero the code within one clock, and a stray strobe from the abandoned ramp counts as a mismatch.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

    // Slew type carried with each command; encoding is fixed by the command port
    typedef enum logic [1:0] {
        SLEW_SOFT  = 2'b00,
        SLEW_FAST  = 2'b01,
        SLEW_SLOW  = 2'b10,
        SLEW_DECAY = 2'b11
    } slew_e;

    typedef enum logic [1:0] {
        PH_OFF  = 2'b00,
        PH_BOOT = 2'b01,
        PH_RUN  = 2'b10
    } phase_e;

endpackage

// File: rtl/vid_target_calc.sv
module vid_target_calc #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] vid,
    input  logic [CODE_W-1:0] offset,
    output logic [CODE_W-1:0] target,
    output logic              shutdown
);
    localparam int SUM_W = CODE_W + 2;

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum      = $signed({2'b00, vid}) + $signed({{2{offset[CODE_W-1]}}, offset});
        shutdown = (vid == '0);
        // R8: clamp the offset sum into the code range
        if (shutdown)
            target = '0;
        else if (sum[SUM_W-1])
            target = '0;
        else if (sum[CODE_W])
            target = '1;
        else
            target = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/vid_rate_sel.sv
module vid_rate_sel
    import vid_ramp_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int FRAC_W = 2,
    parameter int DIV_W  = 2,
    parameter int SOFT_Q = 10
) (
    input  slew_e                     mode,
    input  logic [RATE_W-1:0]         fast_rate,
    input  logic [DIV_W-1:0]          slow_div,
    output logic [RATE_W+FRAC_W-1:0]  rate_q
);
    localparam int RQ_W = RATE_W + FRAC_W;
    localparam int NOPT = 2 ** DIV_W;

    logic [RQ_W-1:0] fast_q;
    logic [RQ_W-1:0] slow_opt [NOPT];

    assign fast_q = {fast_rate, {FRAC_W{1'b0}}};

    // R5: one pre-shifted slow rate per divisor setting
    for (genvar g = 0; g < NOPT; g++) begin : g_slow
        assign slow_opt[g] = fast_q >> (NOPT - g);
    end

    always_comb begin
        unique case (mode)
            SLEW_SOFT: rate_q = RQ_W'(SOFT_Q);
            SLEW_SLOW: rate_q = slow_opt[slow_div];
            default:   rate_q = fast_q;   // fast, and decay upward (R7)
        endcase
    end
endmodule

// File: rtl/vid_step_pacer.sv
module vid_step_pacer #(
    parameter int RQ_W   = 10,
    parameter int ACC_W  = 12,
    parameter int STEP_Q = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            active,
    input  logic            clear,
    input  logic [RQ_W-1:0] rate_q,
    output logic            step
);
    logic [ACC_W-1:0] acc_d, acc_q;

    assign step = active && (acc_q >= ACC_W'(STEP_Q));

    always_comb begin
        acc_d = acc_q;
        if (clear || !active) begin
            acc_d = '0;
        end else begin
            if (step) acc_d = acc_d - ACC_W'(STEP_Q);
            if (tick) acc_d = acc_d + ACC_W'(rate_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/vid_ramp.sv
module vid_ramp
    import vid_ramp_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int RATE_W = 8,
    parameter int FRAC_W = 2,
    parameter int DIV_W  = 2,
    parameter int STEP_Q = 20,
    parameter int SOFT_Q = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              enable,
    input  logic              cmd_load,
    input  logic [CODE_W-1:0] cmd_vid,
    input  logic [1:0]        cmd_slew,
    input  logic [CODE_W-1:0] vid_offset,
    input  logic [CODE_W-1:0] boot_code,
    input  logic [RATE_W-1:0] fast_rate,
    input  logic [DIV_W-1:0]  slow_div,
    output logic [CODE_W-1:0] dac_code,
    output logic              ramping,
    output logic              at_target
);
    localparam int RQ_W  = RATE_W + FRAC_W;
    localparam int ACC_W = RQ_W + 2;

    typedef struct packed {
        phase_e            ph;
        slew_e             mode;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] tgt;
        logic              ramp;
        logic              hit;
    } ramp_st_t;

    ramp_st_t          st_d, st_q;
    logic [CODE_W-1:0] eff_tgt;
    logic              go_zero;
    logic [RQ_W-1:0]   rate_q;
    logic              step;
    logic              clr_d;
    slew_e             cmd_kind;

    assign cmd_kind = slew_e'(cmd_slew);

    vid_target_calc #(.CODE_W(CODE_W)) u_tgt (
        .vid      (cmd_vid),
        .offset   (vid_offset),
        .target   (eff_tgt),
        .shutdown (go_zero)
    );

    vid_rate_sel #(.RATE_W(RATE_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W), .SOFT_Q(SOFT_Q)) u_rate (
        .mode      (st_q.mode),
        .fast_rate (fast_rate),
        .slow_div  (slow_div),
        .rate_q    (rate_q)
    );

    vid_step_pacer #(.RQ_W(RQ_W), .ACC_W(ACC_W), .STEP_Q(STEP_Q)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .active (st_q.ramp),
        .clear  (clr_d),
        .rate_q (rate_q),
        .step   (step)
    );

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        clr_d    = 1'b0;
        if (!enable) begin
            // R1: disabled holds everything at zero
            st_d.ph   = PH_OFF;
            st_d.mode = SLEW_SOFT;
            st_d.code = '0;
            st_d.tgt  = '0;
            clr_d     = 1'b1;
        end else if (st_q.ph == PH_OFF) begin
            // R2: soft start from zero toward the boot code
            st_d.ph   = PH_BOOT;
            st_d.mode = SLEW_SOFT;
            st_d.tgt  = boot_code;
            clr_d     = 1'b1;
        end else if (cmd_load) begin
            // R10: retarget from the present code, fresh credit
            st_d.ph   = PH_RUN;
            st_d.mode = cmd_kind;
            st_d.tgt  = eff_tgt;
            clr_d     = 1'b1;
            if (go_zero)
                st_d.code = '0;                       // R9
            else if (cmd_kind == SLEW_DECAY && eff_tgt < st_q.code)
                st_d.code = eff_tgt;                  // R6
        end else if (step && st_q.code != st_q.tgt) begin
            if (st_q.tgt > st_q.code) st_d.code = st_q.code + 1'b1;
            else                      st_d.code = st_q.code - 1'b1;
            st_d.hit = (st_d.code == st_q.tgt);       // R11
        end
        st_d.ramp = (st_d.ph != PH_OFF) && (st_d.code != st_d.tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_OFF, mode: SLEW_SOFT, code: '0, tgt: '0, ramp: 1'b0, hit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code  = st_q.code;
    assign ramping   = st_q.ramp;
    assign at_target = st_q.hit;
endmodule

// File: rtl/vid_ramp_sva.sv
module vid_ramp_sva #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cmd_load,
    input logic [CODE_W-1:0] cmd_vid,
    input logic [CODE_W-1:0] dac_code,
    input logic              ramping,
    input logic              at_target
);
    assert_disabled_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dac_code == '0 && !ramping && !at_target));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cmd_load && !ramping) |=> $stable(dac_code));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramping && $past(ramping)) |->
            (dac_code == $past(dac_code) ||
             dac_code == $past(dac_code) + 1'b1 ||
             dac_code == $past(dac_code) - 1'b1));

    assert_shutdown_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cmd_load && cmd_vid == '0) |=> (dac_code == '0));

    assert_strobe_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        at_target |=> !at_target);

    assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        at_target |-> !ramping);
endmodule

bind vid_ramp vid_ramp_sva #(.CODE_W(CODE_W)) u_vid_ramp_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cmd_load  (cmd_load),
    .cmd_vid   (cmd_vid),
    .dac_code  (dac_code),
    .ramping   (ramping),
    .at_target (at_target)
);

// File: tb/test_vid_ramp.sv
module test_vid_ramp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       enable = 1'b0;
    logic       cmd_load = 1'b0;
    logic [7:0] cmd_vid = '0;
    logic [1:0] cmd_slew = '0;
    logic [7:0] vid_offset = '0;
    logic [7:0] boot_code = 8'h0C;
    logic [7:0] fast_rate = 8'd10;
    logic [1:0] slow_div = 2'd2;
    logic [7:0] dac_code;
    logic       ramping;
    logic       at_target;

    int n_chk = 0;
    int n_bad = 0;
    int tick_total = 0;
    int tick_base = 0;
    logic [2:0] ph = '0;
    logic prev_hit = 1'b0;

    int    q_code[$];
    int    q_ticks[$];
    string q_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    vid_ramp i_vid_ramp (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .enable(enable),
        .cmd_load(cmd_load), .cmd_vid(cmd_vid), .cmd_slew(cmd_slew),
        .vid_offset(vid_offset), .boot_code(boot_code), .fast_rate(fast_rate),
        .slow_div(slow_div), .dac_code(dac_code), .ramping(ramping), .at_target(at_target)
    );

    // one tick every 8 clocks
    always @(negedge clk) begin
        ph      <= ph + 3'd1;
        us_tick <= (ph == 3'd7);
        if (ph == 3'd7) tick_total <= tick_total + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ticks_for(input int n, input int rq);
        return (20 * n + rq - 1) / rq;
    endfunction

    function automatic int rate_of(input logic [1:0] kind);
        case (kind)
            2'b00:   return 10;
            2'b10:   return (4 * int'(fast_rate)) >> (4 - int'(slow_div));
            default: return 4 * int'(fast_rate);
        endcase
    endfunction

    // monitor: pop expected strobes and compare
    always @(negedge clk) begin
        if (rst_n && at_target) begin
            if (prev_hit) chk("R11 strobe width", 2, 1);
            chk("R11 ramping low at strobe", int'(ramping), 0);
            if (q_code.size() == 0) begin
                chk("R10 unexpected strobe", 1, 0);
            end else begin
                chk({q_tag[0], " landing code"}, int'(dac_code), q_code[0]);
                chk({q_tag[0], " landing tick"}, tick_total - tick_base, q_ticks[0]);
                void'(q_code.pop_front());
                void'(q_ticks.pop_front());
                void'(q_tag.pop_front());
            end
        end
        prev_hit = at_target;
    end

    task automatic sync();
        @(negedge clk);
        while (ph != 3'd2) @(negedge clk);
    endtask

    // driver: issue a command and push the expected landing if paced
    task automatic issue(input logic [7:0] vid, input logic [1:0] kind,
                         input logic [7:0] off, input int tgt, input bit paced,
                         input string tag);
        int n;
        sync();
        cmd_vid = vid; cmd_slew = kind; vid_offset = off; cmd_load = 1'b1;
        tick_base = tick_total;
        n = (tgt > int'(dac_code)) ? tgt - int'(dac_code) : int'(dac_code) - tgt;
        if (paced && n > 0) begin
            q_code.push_back(tgt);
            q_ticks.push_back(ticks_for(n, rate_of(kind)));
            q_tag.push_back(tag);
        end
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic wait_land();
        while (q_code.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(dac_code), 0);
        chk("R1 reset ramping", int'(ramping), 0);
        chk("R1 reset strobe", int'(at_target), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 disabled code", int'(dac_code), 0);

        // R2: soft start to boot code
        sync();
        enable = 1'b1;
        tick_base = tick_total;
        q_code.push_back(12); q_ticks.push_back(24); q_tag.push_back("R2");
        wait_land();
        // R3: hold at boot with no command
        repeat (80) @(negedge clk);
        chk("R3 boot hold code", int'(dac_code), 12);
        chk("R3 boot hold ramping", int'(ramping), 0);

        // R4: fast up
        issue(8'h14, 2'b01, 8'h00, 20, 1'b1, "R4");
        chk("R11 ramping during move", int'(ramping), 1);
        wait_land();
        // R5: slow /4 and /16
        slow_div = 2'd2;
        issue(8'h18, 2'b10, 8'h00, 24, 1'b1, "R5 div4");
        wait_land();
        slow_div = 2'd0;
        issue(8'h1A, 2'b10, 8'h00, 26, 1'b1, "R5 div16");
        wait_land();
        // R8: negative offset, fast down
        issue(8'h10, 2'b01, 8'hFC, 12, 1'b1, "R8 offset");
        wait_land();
        // R6: decay down jumps
        issue(8'h08, 2'b11, 8'h00, 8, 1'b0, "R6");
        chk("R6 decay jump code", int'(dac_code), 8);
        chk("R6 decay ramping", int'(ramping), 0);
        repeat (40) @(negedge clk);
        // R7: decay up is paced at fast
        issue(8'h0E, 2'b11, 8'h00, 14, 1'b1, "R7");
        wait_land();
        // R8: clamp high
        issue(8'hFE, 2'b01, 8'h05, 255, 1'b1, "R8 clamp high");
        wait_land();
        // R8: clamp low via decay
        issue(8'h03, 2'b11, 8'hFB, 0, 1'b0, "R8 clamp low");
        chk("R8 clamp low code", int'(dac_code), 0);
        // R10: retarget mid-ramp in the opposite direction
        slow_div = 2'd2;
        issue(8'h10, 2'b10, 8'h00, 16, 1'b0, "R10 abandoned");
        repeat (48) @(negedge clk);
        chk("R10 mid-ramp moving", int'(ramping), 1);
        issue(8'h01, 2'b01, 8'h00, 1, 1'b1, "R10");
        wait_land();
        // R9: shutdown from a nonzero code
        issue(8'h06, 2'b01, 8'h00, 6, 1'b1, "R4 pre-shutdown");
        wait_land();
        issue(8'h00, 2'b10, 8'h05, 0, 1'b0, "R9");
        chk("R9 shutdown code", int'(dac_code), 0);
        chk("R9 shutdown ramping", int'(ramping), 0);
        repeat (40) @(negedge clk);
        // R1: enable drop mid-ramp
        issue(8'h40, 2'b01, 8'h00, 64, 1'b0, "R1 abandoned");
        repeat (16) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 enable drop code", int'(dac_code), 0);
        chk("R1 enable drop ramping", int'(ramping), 0);
        repeat (40) @(negedge clk);
        chk("R1 stays zero", int'(dac_code), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule